// File: doc/BRIEF.md
# Track Segment Pair Compatibility Tester

This unit receives two track segments measured in two different detector stations. It decides whether both segments can come from one charged particle that left the nominal collision vertex. Each segment carries an azimuthal angle phi, a polar bin eta, a bend-direction bit, a quality value, a straight-track flag, a station code and a valid bit. The unit runs a chain of window checks in one clock and registers the result. The result is a valid flag, the index of the highest transverse-momentum threshold the pair passes, and a graded quality.

The eta acceptance window, the eta alignment tolerance and a table of phi limits are held in configuration registers. The table has one phi limit for each eta region and each momentum threshold. A write port loads these registers at configuration time. Many instances of this unit would sit side by side to cover every segment pairing. Each instance handles one pair per clock.

Top module: `seg_pair_match`

## Requirements
- R1: The result appears on the outputs one clock edge after the inputs are sampled. If a_vld or b_vld is low, match_vld is 0 and match_thr and match_qual are 0. Any rejected pair also gives all-zero outputs.
- R2: The pair is rejected unless eta_min <= eta <= eta_max holds for both a_eta and b_eta (inclusive bounds).
- R3: The pair is rejected when |a_eta - b_eta| is greater than eta_tol.
- R4: The phi difference is dphi = (b_phi - a_phi) mod 4096, read as a 12-bit two's-complement value, so it wraps across 0. A bend bit of 0 requires dphi >= 0 and a bend bit of 1 requires dphi < 0. Both segments must satisfy this, or the pair is rejected.
- R5: The eta region is a_eta[5:4]. Threshold t (0..3) passes when |dphi| <= the limit stored at configuration address region*4+t. match_thr is the highest passing t. If no threshold passes, the pair is rejected.
- R6: The pair is rejected when a_straight and b_straight are both 1.
- R7: Station codes run from 0 to 3. The pair is rejected when both segments carry the same station code, or when the codes are 0 and 3 in either order.
- R8: For an accepted pair, match_qual[5:4] equals match_thr and match_qual[3:0] equals the smaller of a_qual and b_qual.
- R9: A write with cfg_we high stores cfg_wdata at cfg_addr. Addresses 0..15 hold the phi limits. Addresses 16, 17 and 18 hold eta_min, eta_max and eta_tol, taken from cfg_wdata[5:0]. A write affects pairs sampled from the next clock edge onward. After reset all phi limits are 0, eta_min is 0, eta_max is 63 and eta_tol is 63.
- R10: While rst is high, the registered outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 12 | Configuration write data |
| a_vld | input | 1 | Segment A present |
| a_stn | input | 2 | Segment A station code |
| a_phi | input | 12 | Segment A phi |
| a_eta | input | 6 | Segment A eta bin |
| a_bend | input | 1 | Segment A bend direction |
| a_qual | input | 4 | Segment A quality |
| a_straight | input | 1 | Segment A parallel to beam |
| b_vld | input | 1 | Segment B present |
| b_stn | input | 2 | Segment B station code |
| b_phi | input | 12 | Segment B phi |
| b_eta | input | 6 | Segment B eta bin |
| b_bend | input | 1 | Segment B bend direction |
| b_qual | input | 4 | Segment B quality |
| b_straight | input | 1 | Segment B parallel to beam |
| match_vld | output | 1 | Pair compatible |
| match_thr | output | 2 | Highest passing threshold index |
| match_qual | output | 6 | Graded pair quality |

## Verification
The bench builds the unit with its default parameters. These give 12-bit phi, 6-bit eta, four eta regions and four thresholds, so the whole 16-entry limit table and all three eta registers are reachable through the write port. Phi values near 0 and 4095 exercise the wrap of the modular difference. Limits that shrink from threshold 0 to threshold 3 make every threshold index reachable, and a limit rewritten mid-run shows that new settings are used. Random pairs are drawn close together in phi and eta, so accepted and rejected outcomes both occur often.

// File: rtl/seg_pair_pkg.sv
package seg_pair_pkg;
  localparam int PHI_W_D    = 12;
  localparam int ETA_W_D    = 6;
  localparam int QUAL_W_D   = 4;
  localparam int STN_W_D    = 2;
  localparam int REG_BITS_D = 2;
  localparam int N_THR_D    = 4;

  // Offsets of the eta registers after the phi limit table
  typedef enum logic [1:0] {
    MISC_ETA_MIN = 2'd0,
    MISC_ETA_MAX = 2'd1,
    MISC_ETA_TOL = 2'd2
  } misc_sel_e;
endpackage

// File: rtl/seg_pair_cfg.sv
module seg_pair_cfg
  import seg_pair_pkg::*;
#(
  parameter int PHI_W = 12,
  parameter int ETA_W = 6,
  parameter int N_LIM = 16,
  parameter int AW    = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [AW-1:0]          cfg_addr,
  input  logic [PHI_W-1:0]       cfg_wdata,
  output logic [N_LIM*PHI_W-1:0] lim_flat,
  output logic [ETA_W-1:0]       eta_min,
  output logic [ETA_W-1:0]       eta_max,
  output logic [ETA_W-1:0]       eta_tol
);
  localparam logic [AW-1:0] A_MIN = AW'(N_LIM + int'(MISC_ETA_MIN));
  localparam logic [AW-1:0] A_MAX = AW'(N_LIM + int'(MISC_ETA_MAX));
  localparam logic [AW-1:0] A_TOL = AW'(N_LIM + int'(MISC_ETA_TOL));

  for (genvar i = 0; i < N_LIM; i++) begin : g_lim
    always_ff @(posedge clk) begin
      if (rst) begin
        lim_flat[i*PHI_W +: PHI_W] <= '0;
      end else if (cfg_we && cfg_addr == AW'(i)) begin
        lim_flat[i*PHI_W +: PHI_W] <= cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eta_min <= '0;
      eta_max <= '1;
      eta_tol <= '1;
    end else if (cfg_we) begin
      if (cfg_addr == A_MIN) eta_min <= cfg_wdata[ETA_W-1:0];
      if (cfg_addr == A_MAX) eta_max <= cfg_wdata[ETA_W-1:0];
      if (cfg_addr == A_TOL) eta_tol <= cfg_wdata[ETA_W-1:0];
    end
  end
endmodule

// File: rtl/seg_pair_window.sv
module seg_pair_window #(
  parameter int PHI_W = 12,
  parameter int N_THR = 4,
  parameter int THR_W = 2
) (
  input  logic [PHI_W-1:0]       phi_a,
  input  logic [PHI_W-1:0]       phi_b,
  input  logic [N_THR*PHI_W-1:0] lim_row,
  output logic                   dphi_neg,
  output logic                   any_pass,
  output logic [THR_W-1:0]       best_thr
);
  logic [PHI_W-1:0] dphi;
  logic [PHI_W-1:0] mag;
  logic [N_THR-1:0] pass;

  assign dphi     = phi_b - phi_a;
  assign dphi_neg = dphi[PHI_W-1];
  assign mag      = dphi_neg ? (~dphi + 1'b1) : dphi;

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    assign pass[t] = (mag <= lim_row[t*PHI_W +: PHI_W]);
  end

  assign any_pass = |pass;

  always_comb begin
    best_thr = '0;
    for (int t = 0; t < N_THR; t++) begin
      if (pass[t]) best_thr = THR_W'(t);
    end
  end
endmodule

// File: rtl/seg_pair_match.sv
module seg_pair_match
  import seg_pair_pkg::*;
#(
  parameter int PHI_W    = PHI_W_D,
  parameter int ETA_W    = ETA_W_D,
  parameter int QUAL_W   = QUAL_W_D,
  parameter int STN_W    = STN_W_D,
  parameter int REG_BITS = REG_BITS_D,
  parameter int N_THR    = N_THR_D,
  localparam int N_REG   = 1 << REG_BITS,
  localparam int N_LIM   = N_REG * N_THR,
  localparam int THR_W   = (N_THR > 1) ? $clog2(N_THR) : 1,
  localparam int AW      = $clog2(N_LIM + 3),
  localparam int OQ_W    = THR_W + QUAL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [PHI_W-1:0]  cfg_wdata,
  input  logic              a_vld,
  input  logic [STN_W-1:0]  a_stn,
  input  logic [PHI_W-1:0]  a_phi,
  input  logic [ETA_W-1:0]  a_eta,
  input  logic              a_bend,
  input  logic [QUAL_W-1:0] a_qual,
  input  logic              a_straight,
  input  logic              b_vld,
  input  logic [STN_W-1:0]  b_stn,
  input  logic [PHI_W-1:0]  b_phi,
  input  logic [ETA_W-1:0]  b_eta,
  input  logic              b_bend,
  input  logic [QUAL_W-1:0] b_qual,
  input  logic              b_straight,
  output logic              match_vld,
  output logic [THR_W-1:0]  match_thr,
  output logic [OQ_W-1:0]   match_qual
);
  localparam logic [STN_W-1:0] STN_FIRST = '0;
  localparam logic [STN_W-1:0] STN_LAST  = '1;

  logic [N_LIM*PHI_W-1:0] lim_flat;
  logic [ETA_W-1:0]       eta_min, eta_max, eta_tol;
  logic [REG_BITS-1:0]    region;
  logic [N_THR*PHI_W-1:0] lim_row;
  logic                   dphi_neg, any_pass;
  logic [THR_W-1:0]       best_thr;
  logic                   eta_in_rng, eta_aligned, bend_ok, stn_ok, not_both_straight;
  logic [ETA_W-1:0]       deta;
  logic [QUAL_W-1:0]      qmin;
  logic                   accept;

  seg_pair_cfg #(
    .PHI_W(PHI_W), .ETA_W(ETA_W), .N_LIM(N_LIM), .AW(AW)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .lim_flat(lim_flat),
    .eta_min(eta_min), .eta_max(eta_max), .eta_tol(eta_tol)
  );

  assign region  = a_eta[ETA_W-1 -: REG_BITS];
  assign lim_row = lim_flat[region*N_THR*PHI_W +: N_THR*PHI_W];

  seg_pair_window #(
    .PHI_W(PHI_W), .N_THR(N_THR), .THR_W(THR_W)
  ) u_win (
    .phi_a(a_phi), .phi_b(b_phi), .lim_row(lim_row),
    .dphi_neg(dphi_neg), .any_pass(any_pass), .best_thr(best_thr)
  );

  always_comb begin
    eta_in_rng = (a_eta >= eta_min) && (a_eta <= eta_max) &&
                 (b_eta >= eta_min) && (b_eta <= eta_max);
    deta        = (a_eta >= b_eta) ? (a_eta - b_eta) : (b_eta - a_eta);
    eta_aligned = (deta <= eta_tol);
    bend_ok     = (a_bend == dphi_neg) && (b_bend == dphi_neg);
    stn_ok      = (a_stn != b_stn) &&
                  !((a_stn == STN_FIRST) && (b_stn == STN_LAST)) &&
                  !((a_stn == STN_LAST) && (b_stn == STN_FIRST));
    not_both_straight = !(a_straight && b_straight);
    qmin   = (a_qual < b_qual) ? a_qual : b_qual;
    accept = a_vld && b_vld && eta_in_rng && eta_aligned && bend_ok &&
             stn_ok && not_both_straight && any_pass;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_vld  <= 1'b0;
      match_thr  <= '0;
      match_qual <= '0;
    end else begin
      match_vld  <= accept;
      match_thr  <= accept ? best_thr : '0;
      match_qual <= accept ? {best_thr, qmin} : '0;
    end
  end
endmodule

// File: rtl/seg_pair_match_chk.sv
module seg_pair_match_chk #(
  parameter int STN_W  = 2,
  parameter int QUAL_W = 4,
  parameter int THR_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              a_vld,
  input logic              b_vld,
  input logic [STN_W-1:0]  a_stn,
  input logic [STN_W-1:0]  b_stn,
  input logic              a_straight,
  input logic              b_straight,
  input logic [QUAL_W-1:0] a_qual,
  input logic [QUAL_W-1:0] b_qual,
  input logic              match_vld,
  input logic [THR_W-1:0]  match_thr,
  input logic [THR_W+QUAL_W-1:0] match_qual
);
  localparam logic [STN_W-1:0] SF = '0;
  localparam logic [STN_W-1:0] SL = '1;

  a_r1_missing_segment: assert property (@(posedge clk) disable iff (rst)
    !(a_vld && b_vld) |=> !match_vld);

  a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !match_vld |-> (match_thr == '0 && match_qual == '0));

  a_r6_straight_veto: assert property (@(posedge clk) disable iff (rst)
    (a_straight && b_straight) |=> !match_vld);

  a_r7_station_skip: assert property (@(posedge clk) disable iff (rst)
    ((a_stn == b_stn) || (a_stn == SF && b_stn == SL) || (a_stn == SL && b_stn == SF))
      |=> !match_vld);

  a_r8_thr_field: assert property (@(posedge clk) disable iff (rst)
    match_vld |-> (match_qual[THR_W+QUAL_W-1 -: THR_W] == match_thr));

  a_r8_min_quality: assert property (@(posedge clk) disable iff (rst)
    match_vld |-> (match_qual[QUAL_W-1:0] ==
                   (($past(a_qual) < $past(b_qual)) ? $past(a_qual) : $past(b_qual))));
endmodule

bind seg_pair_match seg_pair_match_chk #(
  .STN_W(STN_W), .QUAL_W(QUAL_W), .THR_W(THR_W)
) u_chk (
  .clk(clk), .rst(rst), .a_vld(a_vld), .b_vld(b_vld),
  .a_stn(a_stn), .b_stn(b_stn), .a_straight(a_straight), .b_straight(b_straight),
  .a_qual(a_qual), .b_qual(b_qual),
  .match_vld(match_vld), .match_thr(match_thr), .match_qual(match_qual)
);

// File: tb/test_seg_pair_match.sv
module test_seg_pair_match;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [11:0] cfg_wdata;
  logic        a_vld, b_vld, a_bend, b_bend, a_straight, b_straight;
  logic [1:0]  a_stn, b_stn;
  logic [11:0] a_phi, b_phi;
  logic [5:0]  a_eta, b_eta;
  logic [3:0]  a_qual, b_qual;
  logic        match_vld;
  logic [1:0]  match_thr;
  logic [5:0]  match_qual;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_lim [16];
  int m_emin, m_emax, m_etol;

  always #5 clk = ~clk;

  seg_pair_match i_seg_pair_match (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .a_vld(a_vld), .a_stn(a_stn), .a_phi(a_phi), .a_eta(a_eta), .a_bend(a_bend),
    .a_qual(a_qual), .a_straight(a_straight),
    .b_vld(b_vld), .b_stn(b_stn), .b_phi(b_phi), .b_eta(b_eta), .b_bend(b_bend),
    .b_qual(b_qual), .b_straight(b_straight),
    .match_vld(match_vld), .match_thr(match_thr), .match_qual(match_qual)
  );

  // Expected {vld, thr, qual} from the requirements
  function automatic logic [8:0] model();
    int d, mag, reg_i, best;
    bit neg, ok;
    int de;
    best = -1;
    d    = (int'(b_phi) - int'(a_phi)) & 4095;
    neg  = (d >= 2048);
    mag  = neg ? 4096 - d : d;
    reg_i = int'(a_eta) / 16;
    for (int t = 0; t < 4; t++) if (mag <= m_lim[reg_i*4+t]) best = t;
    de = int'(a_eta) - int'(b_eta);
    if (de < 0) de = -de;
    ok = a_vld && b_vld;
    ok = ok && a_eta >= m_emin && a_eta <= m_emax && b_eta >= m_emin && b_eta <= m_emax;
    ok = ok && (de <= m_etol);
    ok = ok && (a_bend == neg) && (b_bend == neg);
    ok = ok && (a_stn != b_stn) && !({a_stn, b_stn} == 4'b0011) && !({a_stn, b_stn} == 4'b1100);
    ok = ok && !(a_straight && b_straight);
    ok = ok && (best >= 0);
    if (!ok) return 9'd0;
    return {1'b1, 2'(best), 2'(best), (a_qual < b_qual) ? a_qual : b_qual};
  endfunction

  task automatic chk(input string tag, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got vld=%0b thr=%0d qual=%0h exp vld=%0b thr=%0d qual=%0h",
               tag, got[8], got[7:6], got[5:0], exp[8], exp[7:6], exp[5:0]);
    end
  endtask

  // inputs are set just after a negedge; result is sampled at the next negedge
  task automatic run(input string tag);
    logic [8:0] e;
    e = model();
    @(negedge clk);
    chk(tag, {match_vld, match_thr, match_qual}, e);
  endtask

  task automatic cfg_write(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(addr); cfg_wdata = 12'(data);
    if (addr < 16) m_lim[addr] = data;
    else if (addr == 16) m_emin = data & 63;
    else if (addr == 17) m_emax = data & 63;
    else if (addr == 18) m_etol = data & 63;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic base_pair();
    a_vld = 1; b_vld = 1; a_stn = 2'd1; b_stn = 2'd2;
    a_phi = 12'd1000; b_phi = 12'd1010; a_bend = 0; b_bend = 0;
    a_eta = 6'd20; b_eta = 6'd21; a_qual = 4'd9; b_qual = 4'd6;
    a_straight = 0; b_straight = 0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) m_lim[i] = 0;
    m_emin = 0; m_emax = 63; m_etol = 63;
    rst = 1; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    base_pair();
    repeat (3) @(negedge clk);
    chk("R10 reset clears outputs", {match_vld, match_thr, match_qual}, 9'd0);
    rst = 0;

    // R9: reset defaults (limits 0) accept only dphi == 0, all thresholds pass
    base_pair(); b_phi = a_phi;
    run("R9 default config dphi 0");
    base_pair();
    run("R9 default config dphi 10 rejected");

    // program: limit(r,t) = (64*(r+1)) >> t, eta window 8..55, tol 3
    for (int r = 0; r < 4; r++)
      for (int t = 0; t < 4; t++) cfg_write(r*4+t, (64*(r+1)) >> t);
    cfg_write(16, 8); cfg_write(17, 55); cfg_write(18, 3);

    @(negedge clk);
    base_pair(); run("R5 region1 dphi 10 thr3");
    base_pair(); b_phi = 12'd1100; run("R5 dphi 100 thr0");
    base_pair(); b_phi = 12'd1129; run("R5 dphi 129 exceeds all");
    base_pair(); b_phi = 12'd1128; run("R5 dphi 128 boundary");
    base_pair(); b_phi = 12'd1000 - 12'd40; a_bend = 1; b_bend = 1; run("R4 negative dphi");
    base_pair(); b_bend = 1; run("R4 bend mismatch");
    base_pair(); a_phi = 12'd4090; b_phi = 12'd5; run("R4 wrap positive");
    base_pair(); a_phi = 12'd5; b_phi = 12'd4090; a_bend = 1; b_bend = 1; run("R4 wrap negative");
    base_pair(); a_vld = 0; run("R1 a invalid");
    base_pair(); b_vld = 0; run("R1 b invalid");
    base_pair(); a_eta = 6'd7; b_eta = 6'd8; run("R2 eta below min");
    base_pair(); a_eta = 6'd8; b_eta = 6'd8; run("R2 eta at min");
    base_pair(); a_eta = 6'd55; b_eta = 6'd56; run("R2 eta above max");
    base_pair(); b_eta = 6'd23; run("R3 deta 3 ok");
    base_pair(); b_eta = 6'd24; run("R3 deta 4 reject");
    base_pair(); a_straight = 1; b_straight = 1; run("R6 both straight");
    base_pair(); a_straight = 1; run("R6 one straight ok");
    base_pair(); a_stn = 2'd0; b_stn = 2'd3; run("R7 first-last");
    base_pair(); a_stn = 2'd3; b_stn = 2'd0; run("R7 last-first");
    base_pair(); a_stn = 2'd2; run("R7 same station");
    base_pair(); a_stn = 2'd0; b_stn = 2'd1; a_qual = 4'd2; run("R8 min quality");

    // R9: rewrite one limit mid-run
    cfg_write(5, 200);
    @(negedge clk);
    base_pair(); b_phi = 12'd1150; run("R9 rewritten limit");

    // random pairs
    for (int n = 0; n < 600; n++) begin
      int dl;
      a_vld = ($urandom_range(0, 15) != 0);
      b_vld = ($urandom_range(0, 15) != 0);
      a_stn = 2'($urandom_range(0, 3)); b_stn = 2'($urandom_range(0, 3));
      a_phi = 12'($urandom_range(0, 4095));
      dl = int'($urandom_range(0, 300)) - 150;
      b_phi = a_phi + 12'(dl);
      a_bend = (dl < 0); b_bend = (dl < 0);
      if ($urandom_range(0, 9) == 0) a_bend = ~a_bend;
      a_eta = 6'($urandom_range(0, 63));
      b_eta = 6'(int'(a_eta) + int'($urandom_range(0, 8)) - 4);
      a_qual = 4'($urandom_range(0, 15)); b_qual = 4'($urandom_range(0, 15));
      a_straight = ($urandom_range(0, 3) == 0); b_straight = ($urandom_range(0, 3) == 0);
      run("R5 random pair");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule